// File: doc/BRIEF.md
# Sound Generator Register Port

This block sits between a CPU bus and one or more three-channel programmable sound generators. The CPU sees two byte-wide I/O ports. A write to the select port latches an 8-bit register number. A write to the data port commits a byte to the register number that was latched before it. The register contents come back on a read of the select port. A read of the data port returns nothing useful.

The latched 8-bit number is split into two parts. Its upper nibble picks a generator instance, and its lower nibble picks one of that instance's 16 registers. These registers hold the tone period, noise period, channel enable, level and envelope settings. A small group of stereo mixer control bytes sits at a fixed base near the top of the space. The block stores all of these registers and presents them as flat buses to the downstream sound logic. It also emits a one-cycle write event that the downstream logic can use. Tone generation, the volume curve and audio output belong to other blocks.

Top module: `psg_bus_regif`

## Requirements
- R1: A write with `bus_sel`=0 (select port) latches `bus_wdata` as the register number. It produces no `reg_wr_stb` pulse and changes no stored register.
- R2: A write with `bus_sel`=1 (data port) raises `reg_wr_stb` for exactly the next cycle. During that cycle `reg_wr_addr` holds the latched register number and `reg_wr_data` holds the written byte.
- R3: The latched register number persists until the next select-port write. Successive data-port writes all go to that number, and the last one is the one that stays.
- R4: A read with `bus_sel`=0 loads `bus_rdata` on the next clock edge with the contents of the latched register. A read with `bus_sel`=1 loads `bus_rdata` with 0x00.
- R5: Generator instance g (g < NUM_GEN) owns register numbers 16*g to 16*g+15, and the low nibble is the register index. Register i of instance g appears at bits [(16*g+i)*8 +: 8] of `gen_regs`.
- R6: Mixer control byte k (k < NUM_MIX) sits at register number MIX_BASE+k (default 0xF0). It is stored with all 8 bits and appears at bits [k*8 +: 8] of `mix_regs`.
- R7: Writes to register numbers that belong to no instance and no mixer byte change nothing. Reads of such numbers return 0x00.
- R8: Reserved bits read back as zero. Indices 1, 3, 5 and 13 keep only bits [3:0]. Indices 6, 8, 9 and 10 keep only bits [4:0]. All other indices keep 8 bits.
- R9: Synchronous active-low reset clears the latched number, the write event, `bus_rdata` and all stored registers to zero. A data-port write with no earlier select-port write therefore lands in register 0 of instance 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | CPU write cycle |
| bus_rd | input | 1 | CPU read cycle |
| bus_sel | input | 1 | 0 = select port, 1 = data port |
| bus_wdata | input | 8 | CPU write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after `bus_rd` |
| reg_wr_stb | output | 1 | One-cycle register write event |
| reg_wr_addr | output | 8 | Register number of the write event |
| reg_wr_data | output | 8 | Byte of the write event |
| gen_regs | output | NUM_GEN*128 | All generator registers, flattened |
| mix_regs | output | NUM_MIX*8 | Mixer control bytes, flattened |

## Verification
A wrong latched register number or a wrong decode would not fail loudly. It would put a byte into the wrong instance or register, and nothing at the ports would show it until that location is read back. The bench therefore fills the whole 256-entry space before it reads any of it back, so an aliased or stray write shows up as a wrong byte at some other number. A select-port write that leaked a strobe would show up one cycle later on `reg_wr_stb`. A wrong mask would show up on the first read of the affected index.

// File: rtl/psg_bus_pkg.sv
// Shared constants and the per-register reserved-bit mask for the sound
// generator register port. Assumes 16 registers per generator instance.
package psg_bus_pkg;
    localparam int ADDR_W       = 8;
    localparam int DATA_W       = 8;
    localparam int IDX_W        = 4;
    localparam int REGS_PER_GEN = 1 << IDX_W;
    localparam int INST_W       = ADDR_W - IDX_W;

    // Bits that a given register index keeps; the rest read as zero.
    function automatic logic [DATA_W-1:0] reg_keep_mask(input logic [IDX_W-1:0] idx);
        case (idx)
            4'd1, 4'd3, 4'd5, 4'd13: reg_keep_mask = 8'h0F;
            4'd6, 4'd8, 4'd9, 4'd10: reg_keep_mask = 8'h1F;
            default:                 reg_keep_mask = 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/psg_port_latch.sv
// Captures the two CPU ports. A select-port write only latches the register
// number. A data-port write produces a one-cycle write event carrying the
// latched number and the byte. Assumes at most one port is accessed per cycle.
module psg_port_latch
    import psg_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [ADDR_W-1:0] sel_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    // Latch the register number on a select-port write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_addr <= '0;
        else if (bus_wr && !bus_sel)
            sel_addr <= bus_wdata;
    end

    // Form the one-cycle write event on a data-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= bus_wr && bus_sel;
            if (bus_wr && bus_sel) begin
                wr_addr <= sel_addr;
                wr_data <= bus_wdata;
            end
        end
    end

    AST_SEL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sel) |=> !wr_stb); // R1
    AST_STROBE_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel) |=> (wr_stb && wr_addr == $past(sel_addr) && wr_data == $past(bus_wdata))); // R2
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !$past(bus_wr && bus_sel)) |-> 1'b0); // R2
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && !bus_sel) |=> $stable(sel_addr)); // R3
endmodule

// File: rtl/psg_gen_bank.sv
// Register file of one generator instance: 16 bytes at numbers
// INST*16..INST*16+15. Writes are masked so that reserved bits stay zero.
// Also offers the byte selected by the latched number for readback.
module psg_gen_bank
    import psg_bus_pkg::*;
#(
    parameter int INST = 0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_stb,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic                           rd_hit,
    output logic [DATA_W-1:0]              rd_val,
    output logic [REGS_PER_GEN*DATA_W-1:0] regs_flat
);
    localparam logic [INST_W-1:0] MY_INST = INST_W'(INST);

    logic [DATA_W-1:0] regs [REGS_PER_GEN];
    logic              wr_hit;

    // Decode whether the write event targets this instance.
    always_comb wr_hit = wr_stb && (wr_addr[ADDR_W-1:IDX_W] == MY_INST);

    // Store the masked byte into the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REGS_PER_GEN; i++) regs[i] <= '0;
        end else if (wr_hit) begin
            regs[wr_addr[IDX_W-1:0]] <= wr_data & reg_keep_mask(wr_addr[IDX_W-1:0]);
        end
    end

    // Readback selection for the latched number.
    always_comb begin
        rd_hit = (rd_addr[ADDR_W-1:IDX_W] == MY_INST);
        rd_val = regs[rd_addr[IDX_W-1:0]];
    end

    genvar g;
    generate
        for (g = 0; g < REGS_PER_GEN; g++) begin : g_flat
            assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
        end
    endgenerate

    AST_BANK_IGNORE_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_addr[ADDR_W-1:IDX_W] == MY_INST) |=> $stable(regs_flat)); // R7
    AST_COARSE_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_addr[IDX_W-1:0] == 4'd1) |=> (regs_flat[1*DATA_W+4 +: 4] == 4'h0)); // R8
endmodule

// File: rtl/psg_mix_bank.sv
// Stereo mixer control bytes at MIX_BASE..MIX_BASE+NUM_MIX-1, all bits kept.
// Assumes the range does not overlap a generator instance.
module psg_mix_bank
    import psg_bus_pkg::*;
#(
    parameter int NUM_MIX  = 4,
    parameter int MIX_BASE = 240
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_stb,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic                      rd_hit,
    output logic [DATA_W-1:0]         rd_val,
    output logic [NUM_MIX*DATA_W-1:0] regs_flat
);
    localparam int MIX_END = MIX_BASE + NUM_MIX;

    logic [DATA_W-1:0] regs [NUM_MIX];
    logic              wr_in;
    logic [ADDR_W-1:0] wr_off;
    logic [ADDR_W-1:0] rd_off;

    // Range decode and offsets for write and read.
    always_comb begin
        wr_in  = wr_stb && (int'(wr_addr) >= MIX_BASE) && (int'(wr_addr) < MIX_END);
        wr_off = wr_addr - ADDR_W'(MIX_BASE);
        rd_off = rd_addr - ADDR_W'(MIX_BASE);
        rd_hit = (int'(rd_addr) >= MIX_BASE) && (int'(rd_addr) < MIX_END);
        rd_val = '0;
        for (int k = 0; k < NUM_MIX; k++)
            if (int'(rd_off) == k) rd_val = regs[k];
    end

    // Store a mixer control byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_MIX; k++) regs[k] <= '0;
        end else if (wr_in) begin
            for (int k = 0; k < NUM_MIX; k++)
                if (int'(wr_off) == k) regs[k] <= wr_data;
        end
    end

    genvar k;
    generate
        for (k = 0; k < NUM_MIX; k++) begin : g_flat
            assign regs_flat[k*DATA_W +: DATA_W] = regs[k];
        end
    endgenerate

    AST_MIX_IGNORE_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && int'(wr_addr) >= MIX_BASE && int'(wr_addr) < MIX_END) |=> $stable(regs_flat)); // R6
endmodule

// File: rtl/psg_bus_regif.sv
// Top of the sound generator register port. Ties the port latch to NUM_GEN
// generator banks and the mixer bank, and registers the readback byte.
// Assumes MIX_BASE lies above the numbers used by the generator instances.
module psg_bus_regif
    import psg_bus_pkg::*;
#(
    parameter int NUM_GEN  = 2,
    parameter int NUM_MIX  = 4,
    parameter int MIX_BASE = 240
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   bus_wr,
    input  logic                                   bus_rd,
    input  logic                                   bus_sel,
    input  logic [DATA_W-1:0]                      bus_wdata,
    output logic [DATA_W-1:0]                      bus_rdata,
    output logic                                   reg_wr_stb,
    output logic [ADDR_W-1:0]                      reg_wr_addr,
    output logic [DATA_W-1:0]                      reg_wr_data,
    output logic [NUM_GEN*REGS_PER_GEN*DATA_W-1:0] gen_regs,
    output logic [NUM_MIX*DATA_W-1:0]              mix_regs
);
    localparam int GEN_BITS = REGS_PER_GEN * DATA_W;

    logic [ADDR_W-1:0] sel_addr;
    logic [NUM_GEN-1:0] gen_hit;
    logic [DATA_W-1:0]  gen_val [NUM_GEN];
    logic               mix_hit;
    logic [DATA_W-1:0]  mix_val;
    logic [DATA_W-1:0]  rd_byte;
    logic               rd_any_hit;

    psg_port_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .sel_addr  (sel_addr),
        .wr_stb    (reg_wr_stb),
        .wr_addr   (reg_wr_addr),
        .wr_data   (reg_wr_data)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_GEN; g++) begin : g_bank
            psg_gen_bank #(.INST(g)) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_stb    (reg_wr_stb),
                .wr_addr   (reg_wr_addr),
                .wr_data   (reg_wr_data),
                .rd_addr   (sel_addr),
                .rd_hit    (gen_hit[g]),
                .rd_val    (gen_val[g]),
                .regs_flat (gen_regs[g*GEN_BITS +: GEN_BITS])
            );
        end
    endgenerate

    psg_mix_bank #(.NUM_MIX(NUM_MIX), .MIX_BASE(MIX_BASE)) u_mix (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (reg_wr_stb),
        .wr_addr   (reg_wr_addr),
        .wr_data   (reg_wr_data),
        .rd_addr   (sel_addr),
        .rd_hit    (mix_hit),
        .rd_val    (mix_val),
        .regs_flat (mix_regs)
    );

    // Select the readback byte for the latched number; unclaimed reads give 0.
    always_comb begin
        rd_byte = mix_hit ? mix_val : '0;
        for (int i = 0; i < NUM_GEN; i++)
            if (gen_hit[i]) rd_byte = gen_val[i];
        rd_any_hit = mix_hit || (|gen_hit);
    end

    // Register the read byte; data-port reads return zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= bus_sel ? '0 : rd_byte;
    end

    AST_DATA_PORT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel) |=> (bus_rdata == 8'h00)); // R4
    AST_UNCLAIMED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_sel && !rd_any_hit) |=> (bus_rdata == 8'h00)); // R7
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R4
endmodule

// File: tb/psg_bus_regif_test.sv
// Bench: fills the whole register space through the ports, then reads it all
// back and compares with values computed from the register map.
module psg_bus_regif_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_sel = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        reg_wr_stb;
    logic [7:0]  reg_wr_addr;
    logic [7:0]  reg_wr_data;
    logic [255:0] gen_regs;
    logic [31:0] mix_regs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    psg_bus_regif uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .reg_wr_stb(reg_wr_stb), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .gen_regs(gen_regs), .mix_regs(mix_regs)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] keep(input int idx);
        if (idx == 1 || idx == 3 || idx == 5 || idx == 13) return 8'h0F;
        if (idx == 6 || idx == 8 || idx == 9 || idx == 10) return 8'h1F;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] pattern(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    // Expected readback of register number a after the full sweep.
    function automatic logic [7:0] expect_rd(input int a);
        if (a < 32) return pattern(a) & keep(a % 16);
        if (a >= 240 && a < 244) return pattern(a);
        return 8'h00;
    endfunction

    task automatic sel_write(input logic [7:0] a);
        bus_wr = 1'b1; bus_sel = 1'b0; bus_wdata = a;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R1", reg_wr_stb, 0);
    endtask

    task automatic data_write(input logic [7:0] d, input logic [7:0] a_exp, input bit chk);
        bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (chk) begin
            check("R2", reg_wr_stb, 1);
            check("R2", reg_wr_addr, a_exp);
            check("R2", reg_wr_data, d);
        end
        @(negedge clk);
        if (chk) check("R2", reg_wr_stb, 0);
    endtask

    task automatic read_port(input logic sel, output logic [7:0] v);
        bus_rd = 1'b1; bus_sel = sel;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", bus_rdata, 0);
        check("R9", reg_wr_stb, 0);
        check("R9", (gen_regs == '0) && (mix_regs == '0), 1);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: data write with no select write goes to number 0
        data_write(8'hC3, 8'h00, 1'b1);
        check("R9", gen_regs[7:0], 8'hC3);
        read_port(1'b0, v);
        check("R9", v, 8'hC3);
        // R3: latched number persists; last data write wins
        sel_write(8'h12);
        data_write(8'h33, 8'h12, 1'b1);
        data_write(8'h44, 8'h12, 1'b1);
        read_port(1'b0, v);
        check("R3", v, 8'h44);
        check("R5", gen_regs[(16+2)*8 +: 8], 8'h44);
        // R1: select writes alone store nothing
        sel_write(8'h10);
        data_write(8'h5A, 8'h10, 1'b1);
        sel_write(8'h11);
        sel_write(8'h13);
        check("R1", gen_regs[(16+1)*8 +: 8], 8'h00);
        check("R1", gen_regs[(16+3)*8 +: 8], 8'h00);
        sel_write(8'h10);
        read_port(1'b0, v);
        check("R1", v, 8'h5A);
        // R4: data-port read returns zero
        read_port(1'b1, v);
        check("R4", v, 8'h00);
        // Sweep: write every number, then read every number back.
        for (int a = 0; a < 256; a++) begin
            sel_write(8'(a));
            data_write(pattern(a), 8'(a), 1'b1);
        end
        for (int a = 0; a < 256; a++) begin
            sel_write(8'(a));
            read_port(1'b0, v);
            if (a < 32)       check("R8", v, expect_rd(a));
            else if (a >= 240) check("R6", v, expect_rd(a));
            else              check("R7", v, expect_rd(a));
        end
        // R5/R6: flattened outputs
        for (int a = 0; a < 32; a++)
            check("R5", gen_regs[a*8 +: 8], expect_rd(a));
        for (int k = 0; k < 4; k++)
            check("R6", mix_regs[k*8 +: 8], pattern(240 + k));
        // R9: reset clears stored state again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R9", (gen_regs == '0) && (mix_regs == '0) && (bus_rdata == 0), 1);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule